// File: doc/BRIEF.md
# Shared Signed/Unsigned Magnitude Comparator

A combinational comparator for two N-bit words. A mode input selects whether the words are read as plain unsigned magnitudes or as two's-complement signed values. The block drives three flags: greater-than, equal and less-than.

Both modes use one unsigned comparator that works on the N-1 low bits. Only a small amount of logic on the top bit depends on the mode.

In unsigned mode, a word with a set top bit is always the larger when the top bits differ. In signed mode, the word with a clear top bit is the larger when the top bits differ. When the top bits match, the low-bit result decides in either mode. This also holds for two negative numbers, because a larger low part still means a larger two's-complement value.

Top module: `mag_cmp_shared`

## Requirements
- R1: With `is_signed` = 0, `gt` is 1 exactly when `opa` > `opb` as unsigned N-bit numbers.
- R2: With `is_signed` = 0 and differing top bits (bit N-1), `gt` is 1 exactly when `opa` has its top bit set.
- R3: When the top bits of the two words are equal, in either mode, `gt` equals the unsigned comparison of bits N-2..0. For N=4 in signed mode, 4'b1111 > 4'b1100 > 4'b1001.
- R4: With `is_signed` = 1 and differing top bits, `gt` is 1 exactly when `opa` has its top bit clear, meaning `opa` is non-negative.
- R5: With `is_signed` = 1, `gt` is 1 exactly when `opa` > `opb` as two's-complement numbers.
- R6: `eq` is 1 exactly when `opa` and `opb` are bitwise identical, whatever the value of `is_signed`.
- R7: `lt` is 1 exactly when neither `gt` nor `eq` is 1, so exactly one of the three flags is high for every input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | N | First operand |
| opb | input | N | Second operand |
| is_signed | input | 1 | 1: two's-complement compare; 0: unsigned compare |
| gt | output | 1 | `opa` is greater than `opb` |
| eq | output | 1 | `opa` equals `opb` |
| lt | output | 1 | `opa` is less than `opb` |

## Verification
The bench is built with N=4 and covers every operand pair in both modes. This reaches each sign-bit combination, including the pairs of two negative values.

- A design that inverts the top-bit rule in one mode, or swaps the two modes, gets every mixed-top-bit pair wrong in that mode.
- A design that sends the full words to the shared comparator in signed mode orders negative numbers above positive ones.
- A design that lets the mode touch the equality path, or derives `lt` badly, raises no flag or two flags on the equal pairs.

// File: rtl/mag_cmp_shared.sv
module mag_cmp_shared #(
  parameter int N = 8
) (
  input  logic [N-1:0] opa,
  input  logic [N-1:0] opb,
  input  logic         is_signed,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  localparam int LOW_W = N - 1;
  localparam int TOP   = N - 1;

  logic [LOW_W-1:0] low_a, low_b;
  logic             low_gt;
  logic             top_split;
  logic             top_win;

  assign low_a  = opa[LOW_W-1:0];
  assign low_b  = opb[LOW_W-1:0];
  assign low_gt = low_a > low_b;

  assign top_split = opa[TOP] ^ opb[TOP];
  assign top_win   = opa[TOP] ^ is_signed;

  assign gt = top_split ? top_win : low_gt;
  assign eq = (opa == opb);
  assign lt = ~gt & ~eq;
endmodule

module mag_cmp_shared_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] opa,
  input logic [N-1:0] opb,
  input logic         is_signed,
  input logic         gt,
  input logic         eq,
  input logic         lt
);
  always_comb begin
    AST_ONE_FLAG: assert ($countones({gt, eq, lt}) == 1) else $error("flag count"); // R7
    AST_EQ_SAME: assert (eq == (opa == opb)) else $error("eq mismatch"); // R6
    AST_UNS_TOP: assert (!(!is_signed && (opa[N-1] != opb[N-1])) || (gt == opa[N-1])) else $error("unsigned top"); // R2
    AST_SGN_TOP: assert (!(is_signed && (opa[N-1] != opb[N-1])) || (gt == opb[N-1])) else $error("signed top"); // R4
    AST_LOW_DECIDES: assert (!(opa[N-1] == opb[N-1]) || (gt == (opa[N-2:0] > opb[N-2:0]))) else $error("low decide"); // R3
  end
endmodule

bind mag_cmp_shared mag_cmp_shared_chk #(.N(N)) u_chk (.*);

// File: tb/test_mag_cmp_shared.sv
module test_mag_cmp_shared;
  localparam int N = 4;

  typedef struct {
    logic [N-1:0] a;
    logic [N-1:0] b;
    logic         m;
    logic         gt;
    logic         eq;
    logic         lt;
    string        tag;
  } item_t;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] opa = '0, opb = '0;
  logic is_signed = 0;
  logic gt, eq, lt;
  int total = 0, bad = 0;
  bit done = 0;
  item_t sb[$];

  always #5 clk = ~clk;

  mag_cmp_shared #(.N(N)) i_mag_cmp_shared (
    .opa(opa), .opb(opb), .is_signed(is_signed),
    .gt(gt), .eq(eq), .lt(lt)
  );

  task automatic drive(input logic [N-1:0] a, input logic [N-1:0] b, input logic m);
    item_t it;
    @(posedge clk);
    opa = a; opb = b; is_signed = m;
    it.a = a; it.b = b; it.m = m;
    it.gt = m ? ($signed(a) > $signed(b)) : (a > b);
    it.eq = (a == b);
    it.lt = !it.gt && !it.eq;
    if (a == b) it.tag = "R6 R7";
    else if (!m && a[N-1] != b[N-1]) it.tag = "R1 R2 R7";
    else if (!m) it.tag = "R1 R3 R7";
    else if (a[N-1] != b[N-1]) it.tag = "R4 R5 R7";
    else it.tag = "R3 R5 R7";
    sb.push_back(it);
  endtask

  always @(negedge clk) begin
    if (rst_n && sb.size() > 0) begin
      item_t e;
      e = sb.pop_front();
      total++;
      if ({gt, eq, lt} !== {e.gt, e.eq, e.lt}) begin
        bad++;
        $display("FAIL %s a=%b b=%b signed=%0d got gt/eq/lt=%b%b%b expected=%b%b%b",
                 e.tag, e.a, e.b, e.m, gt, eq, lt, e.gt, e.eq, e.lt);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    total++;
    if ({gt, eq, lt} !== 3'b010) begin
      bad++;
      $display("FAIL R6 reset state got=%b%b%b expected=010", gt, eq, lt);
    end
    rst_n = 1;
    // R3 example chain in signed mode
    drive(4'b1111, 4'b1100, 1);
    drive(4'b1100, 4'b1001, 1);
    drive(4'b1001, 4'b1111, 1);
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << N); a++)
        for (int b = 0; b < (1 << N); b++)
          drive(a[N-1:0], b[N-1:0], m[0]);
    while (sb.size() > 0) @(posedge clk);
    @(posedge clk);
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule